// File: doc/BRIEF.md
# I2C Bus Recovery Clock Pulser

This block frees an I2C bus when a stuck target device holds SDA low. Software writes a recovery command, and the block takes control of SCL. It drives SCL low for one timing interval and then releases it for one interval. At the end of each released interval it reads SDA. It stops on the first pulse after which SDA reads high. If SDA never goes high, it stops after a fixed maximum number of pulses. In both cases it then sets a sticky completion flag. Software clears that flag by writing a one to it.

The SCL timing generator paces the pulses with a single-cycle `tick`. SCL is open-drain, so `scl_oe` high means the pin is pulled low. The block also registers the sampled SCL and SDA levels. Software reads these levels to decide whether the recovery worked. The command is ignored while the byte engine is busy, and also while a recovery is already running.

All pins are plain control and status levels or strobes. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, `scl_oe`, `recover_active` and `done_flag` are 0, and `sda_level` and `scl_level` are 1.
- R2: A `recover_req` strobe while the block is idle and `engine_busy` is 0 makes `recover_active` and `scl_oe` go high on the next clock edge.
- R3: While a recovery runs, `scl_oe` changes only on clock edges where `tick` is high. Every low phase after the first lasts exactly one tick period.
- R4: SDA is sampled on the tick that ends each released (high) phase. If it reads 1, no further low phase follows, and `recover_active` drops on that edge.
- R5: If SDA is already high when the command arrives, exactly one pulse is generated.
- R6: At most MAX_PULSES pulses are generated (8 by default). After the last one the recovery ends whatever SDA reads.
- R7: `done_flag` goes high on the same edge on which `recover_active` drops. It then stays high until it is cleared.
- R8: A `done_clr` strobe clears `done_flag` on the next edge. If the clear arrives in the same cycle as a completion, the completion wins and the flag stays set.
- R9: A `recover_req` is ignored while `engine_busy` is 1. A `recover_req` is also ignored while a recovery is running: no restart, and the pulse total is unchanged.
- R10: `sda_level` and `scl_level` show the `sda_in` and `scl_in` samples from one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pacing strobe from the SCL timing generator; one strobe per half SCL period |
| recover_req | input | 1 | One-cycle recovery command strobe |
| engine_busy | input | 1 | High while the byte engine owns the bus |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| done_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| scl_oe | output | 1 | Open-drain enable; 1 pulls SCL low |
| recover_active | output | 1 | High while a recovery sequence is running |
| done_flag | output | 1 | Sticky recovery-complete status bit |
| sda_level | output | 1 | Registered SDA level |
| scl_level | output | 1 | Registered SCL level |

## Verification
The assertions make these assumptions about the inputs:
- `tick` is a single-cycle strobe.
- `recover_req` and `done_clr` are single-cycle strobes.
- `sda_in` only changes well inside a released phase, never on the sampling tick itself.

The stimulus meets these conditions. It drives every input on the falling clock edge. A fixed divider produces `tick` once every four cycles. A bus model releases SDA only after it has counted a set number of completed SCL pulses, so SDA always settles at least one tick period before it is sampled.

// File: rtl/i2c_bus_recover_pkg.sv
package i2c_bus_recover_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_LOW  = 2'd1,
    RS_HIGH = 2'd2
  } rcv_state_e;
endpackage

// File: rtl/rcv_pulse_fsm.sv
module rcv_pulse_fsm
  import i2c_bus_recover_pkg::*;
#(
  parameter int MAX_PULSES = 8,
  localparam int CNT_W = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cmd,
  input  logic engine_busy,
  input  logic sda_in,
  output logic scl_oe,
  output logic active,
  output logic finish
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PULSES);

  rcv_state_e       state;
  logic [CNT_W-1:0] pulses;
  logic             start;

  assign start  = (state == RS_IDLE) && cmd && !engine_busy;
  assign finish = (state == RS_HIGH) && tick && (sda_in || (pulses == CNT_MAX));
  assign scl_oe = (state == RS_LOW);
  assign active = (state != RS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RS_IDLE;
      pulses <= '0;
    end else begin
      unique case (state)
        RS_IDLE: if (start) begin
          state  <= RS_LOW;
          pulses <= '0;
        end
        RS_LOW: if (tick) begin
          state  <= RS_HIGH;
          pulses <= pulses + 1'b1;
        end
        RS_HIGH: if (tick) begin
          state <= finish ? RS_IDLE : RS_LOW;
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  // R2
  start_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_IDLE && cmd && !engine_busy) |=> (scl_oe && active));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_IDLE && cmd && engine_busy) |=> !active);
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(pulses));
  // R3
  oe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(scl_oe));
  // R4
  release_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_HIGH && tick && sda_in) |=> !active);
  // R6
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pulses <= CNT_MAX));
endmodule

// File: rtl/rcv_done_flag.sv
module rcv_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/rcv_line_sense.sv
module rcv_line_sense #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  output logic [LINES-1:0] line_q
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[g] <= 1'b1;
      else        line_q[g] <= line_in[g];
    end
  end

  // R10
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (line_q == $past(line_in)));
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int MAX_PULSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic recover_req,
  input  logic engine_busy,
  input  logic sda_in,
  input  logic scl_in,
  input  logic done_clr,
  output logic scl_oe,
  output logic recover_active,
  output logic done_flag,
  output logic sda_level,
  output logic scl_level
);
  logic       finish;
  logic [1:0] lines_q;

  rcv_pulse_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cmd         (recover_req),
    .engine_busy (engine_busy),
    .sda_in      (sda_in),
    .scl_oe      (scl_oe),
    .active      (recover_active),
    .finish      (finish)
  );

  rcv_done_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (finish),
    .clr   (done_clr),
    .flag  (done_flag)
  );

  rcv_line_sense #(.LINES(2)) u_sense (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in ({scl_in, sda_in}),
    .line_q  (lines_q)
  );

  assign sda_level = lines_q[0];
  assign scl_level = lines_q[1];

  // R7
  done_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recover_active) |-> $rose(done_flag) || $past(done_flag));
endmodule

// File: tb/i2c_bus_recover_tb_top.sv
`timescale 1ns/100ps
module i2c_bus_recover_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic recover_req = 1'b0;
  logic engine_busy = 1'b0;
  logic sda_in;
  logic scl_in = 1'b1;
  logic done_clr = 1'b0;
  logic scl_oe, recover_active, done_flag, sda_level, scl_level;

  int checks = 0;
  int fails = 0;
  int pcount = 0;
  int base_cnt = 0;
  int rel_cur = 0;
  int cur_len = 0;
  int last_low = 0;
  int tdiv = 0;
  logic prev_oe = 1'b0;

  localparam int VEC_N = 5;
  localparam int REL_TAB [VEC_N] = '{0, 1, 3, 8, 9};
  localparam int EXP_TAB [VEC_N] = '{1, 1, 3, 8, 8};

  always #2.5 clk = ~clk;

  i2c_bus_recover dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .recover_req(recover_req),
    .engine_busy(engine_busy), .sda_in(sda_in), .scl_in(scl_in),
    .done_clr(done_clr), .scl_oe(scl_oe), .recover_active(recover_active),
    .done_flag(done_flag), .sda_level(sda_level), .scl_level(scl_level)
  );

  assign sda_in = ((pcount - base_cnt) >= rel_cur);

  always @(negedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 3);
  end

  always @(negedge clk) begin
    if (scl_oe) cur_len <= cur_len + 1;
    if (!scl_oe && prev_oe) begin
      pcount   <= pcount + 1;
      last_low <= cur_len;
      cur_len  <= 0;
    end
    prev_oe <= scl_oe;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_cmd();
    @(negedge clk) recover_req = 1'b1;
    @(negedge clk) recover_req = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (!recover_active) break;
    end
  endtask

  task automatic clear_done();
    @(negedge clk) done_clr = 1'b1;
    @(negedge clk) done_clr = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 scl_oe", int'(scl_oe), 0);
    check("R1 active", int'(recover_active), 0);
    check("R1 done", int'(done_flag), 0);
    check("R1 scl_level", int'(scl_level), 1);
    check("R1 sda_level", int'(sda_level), 1);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < VEC_N; v++) begin
      base_cnt = pcount;
      rel_cur = REL_TAB[v];
      @(negedge clk) recover_req = 1'b1;
      @(negedge clk) recover_req = 1'b0;
      #1;
      check("R2 start drives scl", int'(scl_oe), 1);
      wait_end();
      check((REL_TAB[v] == 0) ? "R5 single pulse" :
            (REL_TAB[v] >= 8) ? "R6 pulse cap" : "R4 early stop",
            pcount - base_cnt, EXP_TAB[v]);
      check("R7 done set", int'(done_flag), 1);
      if (EXP_TAB[v] > 1) check("R3 low phase length", last_low, 4);
      repeat (6) @(negedge clk);
      #1;
      check("R7 done held", int'(done_flag), 1);
      check("R4 no pulse after end", pcount - base_cnt, EXP_TAB[v]);
      clear_done();
      check("R8 clear", int'(done_flag), 0);
    end

    // R9: command ignored while byte engine busy
    base_cnt = pcount; rel_cur = 0;
    engine_busy = 1'b1;
    pulse_cmd();
    repeat (12) @(negedge clk);
    #1;
    check("R9 busy ignored active", int'(recover_active), 0);
    check("R9 busy ignored pulses", pcount - base_cnt, 0);
    check("R9 busy ignored done", int'(done_flag), 0);
    @(negedge clk) engine_busy = 1'b0;

    // R9: second command mid-run does not restart
    base_cnt = pcount; rel_cur = 100;
    pulse_cmd();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (pcount - base_cnt >= 2) break;
    end
    pulse_cmd();
    wait_end();
    check("R9 no restart", pcount - base_cnt, 8);
    clear_done();

    // R8: clear coinciding with completion loses to set
    base_cnt = pcount; rel_cur = 0;
    pulse_cmd();
    @(negedge clk) done_clr = 1'b1;
    wait_end();
    done_clr = 1'b0;
    check("R8 set wins over clear", int'(done_flag), 1);
    clear_done();
    check("R8 clear after", int'(done_flag), 0);

    // R10: line levels
    base_cnt = pcount; rel_cur = 100;
    @(negedge clk) scl_in = 1'b0;
    @(negedge clk); #1;
    check("R10 scl_level low", int'(scl_level), 0);
    check("R10 sda_level low", int'(sda_level), 0);
    rel_cur = 0;
    @(negedge clk) scl_in = 1'b1;
    @(negedge clk); #1;
    check("R10 scl_level high", int'(scl_level), 1);
    check("R10 sda_level high", int'(sda_level), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule